// File: doc/BRIEF.md
# Compare-Branch Fusing Decode Group

This stage takes a group of up to four pre-classified instructions per cycle, ordered oldest first, and places them onto a decoder group. The group has one complex decoder, which may emit up to four micro-ops, and three simple decoders, which emit one micro-op each. At most seven micro-ops leave the stage per cycle. When a compare or test instruction is followed immediately by a conditional branch in the same group, the two are merged into a single fused compare-and-branch micro-op. Only one such merge happens per cycle.

Each input slot carries a valid bit, a two-bit class and a micro-op count. The class codes are 0 for plain, 1 for compare/test, 2 for conditional branch and 3 for unconditional branch. Slot 0 is the oldest. The stage returns `take_cnt`, the number of instructions it accepted this cycle, with a fused pair counted as two. The front end shifts its queue by that amount and presents the rest again in the next cycle. The micro-op list is registered and handed downstream over a valid/ready pair. While `out_valid` is high and `out_ready` is low, the registered list holds, `in_ready` is low and `take_cnt` is zero, so the front end must present the same group again. A new group is accepted on every cycle in which `in_ready` is high.

Each output entry carries a valid bit, a fused flag and the index of the input slot that produced it. The entries are packed from entry 0 in program order.

Top module: `dfz_fuse_decode`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and every bit of `out_uop_vld` is 0.
- R2: An instruction with a micro-op count of 1 yields exactly one micro-op. Up to four such instructions are placed per cycle. The complex decoder takes a single-op instruction once the three simple decoders are in use.
- R3: An instruction with a micro-op count of 2 to 4 can only use the complex decoder. It yields that many consecutive micro-ops, all tagged with its slot index.
- R4: Placement stops at the first instruction that finds no free suitable decoder, for example a second multi-op instruction. `take_cnt` counts only the instructions before it. The remainder, presented again, is decoded in the next cycle.
- R5: A class-1 instruction directly followed by a valid class-2 instruction in the same group becomes one micro-op. That micro-op has its fused flag set, carries the compare's slot index and counts as 2 in `take_cnt`.
- R6: At most one fused micro-op is produced per cycle, and it comes from the oldest eligible pair. Any later eligible pair is decoded as two separate micro-ops.
- R7: No fusion occurs when the compare is the last valid instruction of the group. No fusion occurs when the following instruction has a class other than 2, including class 3.
- R8: Output entries are packed from entry 0. Their slot indexes never decrease, and `out_uop_cnt` equals the number of set bits in `out_uop_vld`.
- R9: While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values, `in_ready` is 0 and `take_cnt` is 0.
- R10: With `in_valid[0]` at 0, `take_cnt` is 0, and `out_valid` falls at the next accepting edge.
- R11: Slots after the first invalid slot are ignored, even when they are marked valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 4 | Per-slot valid, bit 0 oldest |
| in_class | input | 8 | Two-bit class per slot, slot i at [2i+1:2i] |
| in_nuops | input | 12 | Three-bit micro-op count per slot, slot i at [3i+2:3i] |
| in_ready | output | 1 | Stage can accept a group this cycle |
| take_cnt | output | 3 | Instructions accepted this cycle |
| out_valid | output | 1 | Registered micro-op list is valid |
| out_ready | input | 1 | Downstream accepts the list |
| out_uop_vld | output | 7 | Per-entry valid |
| out_uop_fused | output | 7 | Per-entry fused flag |
| out_uop_src | output | 14 | Two-bit source slot index per entry, entry k at [2k+1:2k] |
| out_uop_cnt | output | 3 | Number of valid entries |

## Verification
The hardest case to reach is fusion competing for decoders. In that case a multi-op instruction already holds the complex decoder and a fused pair must land on a simple decoder, while a second eligible pair in the same group must stay unfused. The stimulus table is built so that class and count patterns overlap in these cases. It places a pair after a three-op instruction, two back-to-back pairs, a compare-compare-branch chain and a branch with no compare ahead of it. Directed steps then present the leftover instructions after a stall, and hold the output under back-pressure while new inputs are offered.

// File: rtl/dfz_pkg.sv
package dfz_pkg;
  typedef enum logic [1:0] {
    ICLS_PLAIN = 2'd0,
    ICLS_CMP   = 2'd1,
    ICLS_BRC   = 2'd2,
    ICLS_JMP   = 2'd3
  } icls_e;
endpackage

// File: rtl/dfz_pair_find.sv
module dfz_pair_find
  import dfz_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic [SLOTS-1:0]   vld,
  input  logic [2*SLOTS-1:0] cls,
  output logic [SLOTS-1:0]   fuse_at
);
  logic [SLOTS-1:0] cand;

  for (genvar i = 0; i < SLOTS - 1; i++) begin : g_pair
    assign cand[i] = vld[i] && vld[i+1] &&
                     (cls[2*i +: 2] == ICLS_CMP) &&
                     (cls[2*(i+1) +: 2] == ICLS_BRC);
  end
  assign cand[SLOTS-1] = 1'b0;

  // keep only the oldest candidate
  assign fuse_at = cand & (~cand + SLOTS'(1));
endmodule

// File: rtl/dfz_slot_alloc.sv
module dfz_slot_alloc #(
  parameter int SLOTS   = 4,
  parameter int CX_UOPS = 4,
  localparam int UOPS   = SLOTS - 1 + CX_UOPS,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int NU_W   = $clog2(CX_UOPS + 1),
  localparam int CNT_W  = $clog2(UOPS + 1),
  localparam int TAKE_W = $clog2(SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SLOTS-1:0]      vld,
  input  logic [NU_W*SLOTS-1:0] nuops,
  input  logic [SLOTS-1:0]      fuse_at,
  output logic [UOPS-1:0]       uop_vld,
  output logic [UOPS-1:0]       uop_fused,
  output logic [IDX_W*UOPS-1:0] uop_src,
  output logic [CNT_W-1:0]      uop_cnt,
  output logic [TAKE_W-1:0]     take_n
);
  int   k;
  int   need;
  int   sp_used;
  logic cx_busy;
  logic halt;
  logic skip_nxt;
  logic placed;

  function automatic int clamp_need(input logic [NU_W-1:0] n);
    if (n == '0) return 1;
    if (int'(n) > CX_UOPS) return CX_UOPS;
    return int'(n);
  endfunction

  always_comb begin
    uop_vld   = '0;
    uop_fused = '0;
    uop_src   = '0;
    take_n    = '0;
    k         = 0;
    need      = 0;
    sp_used   = 0;
    cx_busy   = 1'b0;
    halt      = 1'b0;
    skip_nxt  = 1'b0;
    placed    = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (skip_nxt) begin
        skip_nxt = 1'b0;
      end else if (!halt) begin
        if (!vld[i]) begin
          halt = 1'b1;
        end else begin
          need   = fuse_at[i] ? 1 : clamp_need(nuops[NU_W*i +: NU_W]);
          placed = 1'b0;
          if (need == 1 && sp_used < SLOTS - 1) begin
            sp_used = sp_used + 1;
            placed  = 1'b1;
          end else if (!cx_busy) begin
            cx_busy = 1'b1;
            placed  = 1'b1;
          end
          if (!placed) begin
            halt = 1'b1;
          end else begin
            for (int j = 0; j < CX_UOPS; j++) begin
              if (j < need && k < UOPS) begin
                uop_vld[k]                 = 1'b1;
                uop_fused[k]               = fuse_at[i];
                uop_src[IDX_W*k +: IDX_W]  = IDX_W'(i);
                k = k + 1;
              end
            end
            take_n   = take_n + (fuse_at[i] ? TAKE_W'(2) : TAKE_W'(1));
            skip_nxt = fuse_at[i];
          end
        end
      end
    end
    uop_cnt = CNT_W'(k);
  end

  // R6
  one_fuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(uop_fused) <= 1);

  // R5
  fuse_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_fused & ~uop_vld) == '0);
endmodule

// File: rtl/dfz_out_hold.sv
module dfz_out_hold #(
  parameter int UOPS  = 7,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  load_vld,
  input  logic [UOPS-1:0]       d_vld,
  input  logic [UOPS-1:0]       d_fused,
  input  logic [IDX_W*UOPS-1:0] d_src,
  input  logic [CNT_W-1:0]      d_cnt,
  input  logic                  out_ready,
  output logic                  q_valid,
  output logic [UOPS-1:0]       q_vld,
  output logic [UOPS-1:0]       q_fused,
  output logic [IDX_W*UOPS-1:0] q_src,
  output logic [CNT_W-1:0]      q_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_vld   <= '0;
      q_fused <= '0;
      q_src   <= '0;
      q_cnt   <= '0;
    end else if (load) begin
      q_valid <= load_vld;
      q_vld   <= load_vld ? d_vld   : '0;
      q_fused <= load_vld ? d_fused : '0;
      q_src   <= load_vld ? d_src   : '0;
      q_cnt   <= load_vld ? d_cnt   : '0;
    end
  end

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !out_ready) |=> ($stable(q_vld) && $stable(q_fused) &&
                                 $stable(q_src) && $stable(q_cnt) && q_valid));

  // R8
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> ($countones(q_vld) == int'(q_cnt)));
endmodule

// File: rtl/dfz_fuse_decode.sv
module dfz_fuse_decode #(
  parameter int SLOTS   = 4,
  parameter int CX_UOPS = 4,
  localparam int UOPS   = SLOTS - 1 + CX_UOPS,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int NU_W   = $clog2(CX_UOPS + 1),
  localparam int CNT_W  = $clog2(UOPS + 1),
  localparam int TAKE_W = $clog2(SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SLOTS-1:0]      in_valid,
  input  logic [2*SLOTS-1:0]    in_class,
  input  logic [NU_W*SLOTS-1:0] in_nuops,
  output logic                  in_ready,
  output logic [TAKE_W-1:0]     take_cnt,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [UOPS-1:0]       out_uop_vld,
  output logic [UOPS-1:0]       out_uop_fused,
  output logic [IDX_W*UOPS-1:0] out_uop_src,
  output logic [CNT_W-1:0]      out_uop_cnt
);
  logic [SLOTS-1:0]      fuse_at;
  logic [UOPS-1:0]       a_vld;
  logic [UOPS-1:0]       a_fused;
  logic [IDX_W*UOPS-1:0] a_src;
  logic [CNT_W-1:0]      a_cnt;
  logic [TAKE_W-1:0]     a_take;

  dfz_pair_find #(.SLOTS(SLOTS)) u_pair (
    .vld     (in_valid),
    .cls     (in_class),
    .fuse_at (fuse_at)
  );

  dfz_slot_alloc #(.SLOTS(SLOTS), .CX_UOPS(CX_UOPS)) u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld       (in_valid),
    .nuops     (in_nuops),
    .fuse_at   (fuse_at),
    .uop_vld   (a_vld),
    .uop_fused (a_fused),
    .uop_src   (a_src),
    .uop_cnt   (a_cnt),
    .take_n    (a_take)
  );

  assign in_ready = !out_valid || out_ready;
  assign take_cnt = in_ready ? a_take : '0;

  dfz_out_hold #(.UOPS(UOPS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (in_ready),
    .load_vld  (in_valid[0]),
    .d_vld     (a_vld),
    .d_fused   (a_fused),
    .d_src     (a_src),
    .d_cnt     (a_cnt),
    .out_ready (out_ready),
    .q_valid   (out_valid),
    .q_vld     (out_uop_vld),
    .q_fused   (out_uop_fused),
    .q_src     (out_uop_src),
    .q_cnt     (out_uop_cnt)
  );

  // R10
  empty_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid[0] |-> (take_cnt == '0));

  // R10
  empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid[0]) |=> !out_valid);
endmodule

// File: tb/dfz_fuse_decode_tb.sv
module dfz_fuse_decode_tb;
  typedef struct packed {
    logic [3:0]  v;
    logic [7:0]  c;
    logic [11:0] n;
    logic [2:0]  take;
    logic [2:0]  cnt;
    logic [6:0]  fz;
    logic [13:0] src;
  } vec_t;

  localparam int NV = 15;
  // class/nuops fields listed slot3 .. slot0
  localparam vec_t VECS [NV] = '{
    '{4'b1111, {2'd0,2'd0,2'd0,2'd0}, {3'd1,3'd1,3'd1,3'd1}, 3'd4, 3'd4, 7'h00, 14'h0E4}, // R2
    '{4'b1111, {2'd0,2'd0,2'd0,2'd0}, {3'd1,3'd1,3'd1,3'd3}, 3'd4, 3'd6, 7'h00, 14'hE40}, // R3
    '{4'b1111, {2'd0,2'd0,2'd0,2'd0}, {3'd1,3'd1,3'd2,3'd2}, 3'd1, 3'd2, 7'h00, 14'h000}, // R4
    '{4'b1111, {2'd0,2'd0,2'd0,2'd0}, {3'd2,3'd1,3'd4,3'd1}, 3'd3, 3'd6, 7'h00, 14'h954}, // R4
    '{4'b1111, {2'd0,2'd0,2'd2,2'd1}, {3'd1,3'd1,3'd1,3'd1}, 3'd4, 3'd3, 7'h01, 14'h038}, // R5
    '{4'b1111, {2'd2,2'd1,2'd2,2'd1}, {3'd1,3'd1,3'd1,3'd1}, 3'd4, 3'd3, 7'h01, 14'h038}, // R6
    '{4'b1111, {2'd0,2'd2,2'd1,2'd0}, {3'd1,3'd1,3'd1,3'd1}, 3'd4, 3'd3, 7'h02, 14'h034}, // R5
    '{4'b1111, {2'd1,2'd0,2'd0,2'd0}, {3'd1,3'd1,3'd1,3'd1}, 3'd4, 3'd4, 7'h00, 14'h0E4}, // R7
    '{4'b1111, {2'd0,2'd0,2'd3,2'd1}, {3'd1,3'd1,3'd1,3'd1}, 3'd4, 3'd4, 7'h00, 14'h0E4}, // R7
    '{4'b0011, {2'd0,2'd0,2'd2,2'd1}, {3'd1,3'd1,3'd1,3'd1}, 3'd2, 3'd1, 7'h01, 14'h000}, // R5
    '{4'b0001, {2'd0,2'd0,2'd2,2'd1}, {3'd1,3'd1,3'd1,3'd1}, 3'd1, 3'd1, 7'h00, 14'h000}, // R7
    '{4'b1011, {2'd0,2'd0,2'd0,2'd0}, {3'd1,3'd1,3'd1,3'd1}, 3'd2, 3'd2, 7'h00, 14'h004}, // R11
    '{4'b1111, {2'd0,2'd2,2'd1,2'd2}, {3'd1,3'd1,3'd1,3'd1}, 3'd4, 3'd3, 7'h02, 14'h034}, // R7
    '{4'b1111, {2'd0,2'd2,2'd1,2'd0}, {3'd1,3'd1,3'd1,3'd3}, 3'd4, 3'd5, 7'h08, 14'h340}, // R5
    '{4'b1111, {2'd0,2'd2,2'd1,2'd1}, {3'd1,3'd1,3'd1,3'd1}, 3'd4, 3'd3, 7'h02, 14'h034}  // R6
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R2";   1: return "R3";   2: return "R4";   3: return "R4";
      4: return "R5";   5: return "R6";   6: return "R5";   7: return "R7";
      8: return "R7";   9: return "R5";  10: return "R7";  11: return "R11";
      12: return "R7"; 13: return "R5";  default: return "R6";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  in_valid = '0;
  logic [7:0]  in_class = '0;
  logic [11:0] in_nuops = '0;
  logic        in_ready;
  logic [2:0]  take_cnt;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [6:0]  out_uop_vld;
  logic [6:0]  out_uop_fused;
  logic [13:0] out_uop_src;
  logic [2:0]  out_uop_cnt;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  dfz_fuse_decode u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_nuops(in_nuops), .in_ready(in_ready), .take_cnt(take_cnt),
    .out_valid(out_valid), .out_ready(out_ready), .out_uop_vld(out_uop_vld),
    .out_uop_fused(out_uop_fused), .out_uop_src(out_uop_src),
    .out_uop_cnt(out_uop_cnt)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v, input logic [7:0] c, input logic [11:0] n);
    in_valid = v;
    in_class = c;
    in_nuops = n;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
    chk("R1 uop_vld in reset", 32'(out_uop_vld), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1 uop_vld after reset", 32'(out_uop_vld), 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].v, VECS[i].c, VECS[i].n);
      #1;
      chk({vtag(i), " take_cnt"}, 32'(take_cnt), 32'(VECS[i].take));
      @(negedge clk);
      chk({vtag(i), " out_valid"}, 32'(out_valid), 32'd1);
      chk({vtag(i), " R8 uop_cnt"}, 32'(out_uop_cnt), 32'(VECS[i].cnt));
      chk({vtag(i), " R8 uop_vld"}, 32'(out_uop_vld), (32'd1 << VECS[i].cnt) - 32'd1);
      chk({vtag(i), " fused"}, 32'(out_uop_fused), 32'(VECS[i].fz));
      chk({vtag(i), " R8 src"}, 32'(out_uop_src), 32'(VECS[i].src));
    end

    // R4 remainder: second two-op instruction decoded next cycle
    drive(4'b1111, 8'h00, {3'd1,3'd1,3'd2,3'd2});
    #1 chk("R4 stall take", 32'(take_cnt), 32'd1);
    @(negedge clk);
    drive(4'b0111, 8'h00, {3'd0,3'd1,3'd1,3'd2});
    #1 chk("R4 remainder take", 32'(take_cnt), 32'd3);
    @(negedge clk);
    chk("R4 remainder cnt", 32'(out_uop_cnt), 32'd4);
    chk("R4 remainder src", 32'(out_uop_src), 32'h0000_0090);

    // R9 back-pressure
    drive(4'b1111, 8'h00, {3'd1,3'd1,3'd1,3'd3});
    @(negedge clk);
    out_ready = 1'b0;
    drive(4'b1111, 8'h00, {3'd1,3'd1,3'd1,3'd1});
    #1;
    chk("R9 in_ready low", 32'(in_ready), 32'd0);
    chk("R9 take zero", 32'(take_cnt), 32'd0);
    @(negedge clk);
    chk("R9 held valid", 32'(out_valid), 32'd1);
    chk("R9 held cnt", 32'(out_uop_cnt), 32'd6);
    chk("R9 held src", 32'(out_uop_src), 32'h0000_0E40);
    out_ready = 1'b1;
    #1 chk("R9 resume take", 32'(take_cnt), 32'd4);
    @(negedge clk);
    chk("R9 new cnt", 32'(out_uop_cnt), 32'd4);

    // R10 empty group
    drive(4'b0000, 8'h00, 12'h000);
    #1 chk("R10 empty take", 32'(take_cnt), 32'd0);
    @(negedge clk);
    chk("R10 out_valid falls", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule